// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sequences one bank of asynchronous DRAM for a host that presents read and write requests on a valid/ready handshake. For each accepted request it places the row half of the address on the multiplexed address pins with RAS, then the column half with CAS. It drives write enable during the column strobe of a write, and it pulses a completion strobe in that same cycle so the host knows when to move data. Between accesses it holds RAS high for a programmable precharge time.

An 8-bit configuration register selects the precharge length, fast-page bursting, whether an open row stays open while the host is idle, how far the row address is shifted above the column address, and how long refresh cycles last. An external refresh request starts a CAS-before-RAS refresh at the next access boundary, ahead of any waiting access. A soft reset returns the sequencer to idle and keeps the configuration. A power reset also clears the configuration.

Top module: `dram_page_seq`

## Requirements
- R1: The configuration register reads back the last value written. Its bit 7 selects precharge length, bit 6 enables bursting, bit 5 enables row hold, bit 4 is a stored CAS-width flag with no effect on timing, bits 3:2 hold the address shift code and bits 1:0 the refresh wait count. It is 0x00 after a power reset, and a soft reset leaves it unchanged.
- R2: While either reset is asserted and after its release, RAS, CAS and WE are high (inactive) and reqReady is low until a request arrives.
- R3: When a request waits on a row change, RAS is high between two RAS-low periods for exactly 1 cycle when bit 7 is 0 and exactly 2 cycles when bit 7 is 1.
- R4: A full access runs as follows. The acceptance cycle has reqValid and reqReady high. The next cycle has RAS low, CAS high and the row address on dramAddr. The cycle after that has CAS low, the column address, accDone high, and WE low only for a write. With bursting off, RAS and CAS are both high in the following cycle. WE is high in every other cycle of the access.
- R5: With bit 6 set, a column cycle is followed by one cycle with RAS low and CAS high. A request to the same row is accepted in that cycle, and the next cycle drives CAS low with the new column while RAS never rises.
- R6: With bits 6 and 5 both set and no request pending, RAS stays low indefinitely after a column cycle. With bit 5 set and bit 6 clear, the block behaves as if bit 5 were clear, so RAS is high in the cycle after the column cycle.
- R7: With bit 6 set, bit 5 clear and no request in the open-row cycle, RAS goes high in the next cycle.
- R8: A request to a different row while a row is held open raises RAS, runs the precharge, and then presents the new row address with RAS low.
- R9: A shift code m gives row address = bits [8+m+10 : 8+m] of reqAddr and column address = bits [8+m-1 : 0] of reqAddr, zero-extended to 11 bits.
- R10: A refresh drives CAS low with RAS high for one cycle. Then RAS and CAS are both low for 1+N cycles, where N is bits 1:0, with WE high and refAck high in the last of them. Then RAS and CAS are both high.
- R11: When refReq and a request are both pending at an access boundary (idle, end of precharge or open row), the refresh runs first and reqReady stays low until it completes. From an open row, RAS is raised and precharged before CAS falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPowerN | input | 1 | Power reset, active low, asynchronous; clears configuration and sequencer |
| rstSoftN | input | 1 | Soft reset, active low, synchronous; returns sequencer to idle only |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 8 | Configuration write value |
| cfgRdata | output | 8 | Current configuration value |
| reqValid | input | 1 | Host request valid |
| reqWrite | input | 1 | Request is a write |
| reqAddr | input | ADDR_W | Request word address |
| reqReady | output | 1 | Request accepted this cycle |
| accDone | output | 1 | Column strobe of an access is active |
| refReq | input | 1 | Refresh request level, held until refAck |
| refAck | output | 1 | Last cycle of a refresh |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramAddr | output | MA_W | Multiplexed row/column address |

## Verification
A corrupted sequencer state shows on the strobe pins in the very next cycle. One symptom is RAS rising inside a burst. Another is CAS falling with no preceding RAS-high gap, or refresh CAS arriving after RAS. An error in the latched address or the shift decode shows as a wrong row or column value in the first RAS-low or CAS-low cycle of the access. A wrong open-row comparison shows one cycle later as an unexpected precharge or as a column strobe against the wrong row.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int MUX_W  = 2;
  localparam int REFW_W = 2;

  // Configuration register, most significant field first
  typedef struct packed {
    logic              preLong;   // 1: two precharge cycles
    logic              burstEn;   // fast-page bursting
    logic              rasHold;   // keep row open when idle
    logic              casWide;   // stored flag only
    logic [MUX_W-1:0]  muxSel;    // row shift = 8 + muxSel
    logic [REFW_W-1:0] refWait;   // extra RAS-low refresh cycles
  } seqCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;     // latch request address / direction
    logic selRow;     // drive row half on address pins
    logic rasOn;
    logic casOn;
    logic colAccess;  // column cycle of a host access
  } seqStrb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ROW, S_COL, S_OPEN, S_RCAS, S_RRAS
  } seqState_t;

endpackage

// File: rtl/dram_seq_dpath.sv
module dram_seq_dpath
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int MA_W      = 11,
  parameter int MIN_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstPowerN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output seqCfg_t           cfg,
  input  seqStrb_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              rowHit,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic [MA_W-1:0]   dramAddr
);

  localparam int MAX_SHIFT = MIN_SHIFT + (1 << MUX_W) - 1;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);

  seqCfg_t           cfgReg;
  logic [ADDR_W-1:0] latAddr;
  logic              latWrite;
  logic [SH_W-1:0]   shiftAmt;
  logic [ADDR_W-1:0] rowFull;
  logic [ADDR_W-1:0] reqRowFull;
  logic [ADDR_W-1:0] colMask;
  logic [ADDR_W-1:0] colFull;

  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN) cfgReg <= '0;
    else if (cfgWe) cfgReg <= seqCfg_t'(cfgWdata);
  end

  assign cfg      = cfgReg;
  assign cfgRdata = cfgReg;

  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN) begin
      latAddr  <= '0;
      latWrite <= 1'b0;
    end else if (strb.accept) begin
      latAddr  <= reqAddr;
      latWrite <= reqWrite;
    end
  end

  assign shiftAmt   = SH_W'(MIN_SHIFT) + {{(SH_W-MUX_W){1'b0}}, cfgReg.muxSel};
  assign rowFull    = latAddr >> shiftAmt;
  assign reqRowFull = reqAddr >> shiftAmt;
  assign colMask    = ~({ADDR_W{1'b1}} << shiftAmt);
  assign colFull    = latAddr & colMask;
  assign rowHit     = (rowFull == reqRowFull);

  assign dramAddr = strb.selRow ? MA_W'(rowFull) : MA_W'(colFull);
  assign dramRasN = ~strb.rasOn;
  assign dramCasN = ~strb.casOn;
  assign dramWeN  = ~(strb.colAccess & latWrite);

  // R1: register only changes on a write strobe
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rstPowerN)
    !cfgWe |=> $stable(cfgReg));

  // R5: a page-hit acceptance keeps the open row
  p_page_row_kept_r5: assert property (@(posedge clk) disable iff (!rstPowerN)
    (strb.accept && strb.rasOn && !cfgWe) |=> $stable(rowFull));

  // R4: write enable only inside a RAS and CAS low cycle
  p_we_in_column_r4: assert property (@(posedge clk) disable iff (!rstPowerN)
    !dramWeN |-> (!dramCasN && !dramRasN));

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstPowerN,
  input  logic              rstSoftN,
  input  logic              preLong,
  input  logic              burstEn,
  input  logic              rasHold,
  input  logic [REFW_W-1:0] refWait,
  input  logic              reqValid,
  input  logic              rowHit,
  input  logic              refReq,
  output logic              reqReady,
  output logic              refAck,
  output logic              accDone,
  output seqStrb_t          strb
);

  seqState_t         state, stateNxt;
  logic [REFW_W-1:0] cnt, cntNxt;
  logic [REFW_W-1:0] preLast;
  logic              preDone, refDone, holdEff, accept;

  assign preLast = preLong ? REFW_W'(1) : '0;
  assign preDone = (state == S_PRE)  && (cnt == preLast);
  assign refDone = (state == S_RRAS) && (cnt == refWait);
  assign holdEff = rasHold & burstEn;

  always_comb begin
    stateNxt = state;
    cntNxt   = '0;
    accept   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (refReq) stateNxt = S_RCAS;
        else if (reqValid) begin
          accept   = 1'b1;
          stateNxt = S_ROW;
        end
      end
      S_PRE: begin
        if (!preDone) cntNxt = cnt + 1'b1;
        else if (refReq) stateNxt = S_RCAS;
        else if (reqValid) begin
          accept   = 1'b1;
          stateNxt = S_ROW;
        end else stateNxt = S_IDLE;
      end
      S_ROW:  stateNxt = S_COL;
      S_COL:  stateNxt = burstEn ? S_OPEN : S_PRE;
      S_OPEN: begin
        if (refReq) stateNxt = S_PRE;
        else if (reqValid && rowHit) begin
          accept   = 1'b1;
          stateNxt = S_COL;
        end else if (reqValid || !holdEff) stateNxt = S_PRE;
      end
      S_RCAS: stateNxt = S_RRAS;
      S_RRAS: begin
        if (refDone) stateNxt = S_PRE;
        else cntNxt = cnt + 1'b1;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (!rstSoftN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    strb           = '0;
    strb.accept    = accept & rstSoftN;
    strb.selRow    = (state == S_ROW);
    strb.rasOn     = (state == S_ROW) || (state == S_COL) ||
                     (state == S_OPEN) || (state == S_RRAS);
    strb.casOn     = (state == S_COL) || (state == S_RCAS) || (state == S_RRAS);
    strb.colAccess = (state == S_COL);
  end

  assign reqReady = strb.accept;
  assign accDone  = strb.colAccess;
  assign refAck   = refDone;

  // R10: during refresh CAS is already low when RAS falls
  p_cbr_order_r10: assert property (@(posedge clk) disable iff (!rstPowerN || !rstSoftN)
    ($rose(strb.rasOn) && strb.casOn) |-> $past(strb.casOn));

  // R3: a row strobe only starts from idle or after precharge
  p_row_after_pre_r3: assert property (@(posedge clk) disable iff (!rstPowerN || !rstSoftN)
    ($rose(strb.rasOn) && !strb.casOn) |-> ($past(state) == S_IDLE || $past(state) == S_PRE));

  // R11: no host request taken while a refresh runs
  p_refresh_excl_r11: assert property (@(posedge clk) disable iff (!rstPowerN || !rstSoftN)
    (state == S_RCAS || state == S_RRAS) |-> !reqReady);

  // R5: bursting never holds CAS low across two column cycles
  p_cas_toggle_r5: assert property (@(posedge clk) disable iff (!rstPowerN || !rstSoftN)
    strb.colAccess |=> !strb.colAccess);

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int MA_W      = 11,
  parameter int MIN_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstPowerN,
  input  logic              rstSoftN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              accDone,
  input  logic              refReq,
  output logic              refAck,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic [MA_W-1:0]   dramAddr
);

  seqCfg_t  cfg;
  seqStrb_t strb;
  logic     rowHit;

  dram_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstPowerN(rstPowerN),
    .rstSoftN (rstSoftN),
    .preLong  (cfg.preLong),
    .burstEn  (cfg.burstEn),
    .rasHold  (cfg.rasHold),
    .refWait  (cfg.refWait),
    .reqValid (reqValid),
    .rowHit   (rowHit),
    .refReq   (refReq),
    .reqReady (reqReady),
    .refAck   (refAck),
    .accDone  (accDone),
    .strb     (strb)
  );

  dram_seq_dpath #(
    .ADDR_W   (ADDR_W),
    .MA_W     (MA_W),
    .MIN_SHIFT(MIN_SHIFT)
  ) u_dpath (
    .clk      (clk),
    .rstPowerN(rstPowerN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .cfg      (cfg),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .rowHit   (rowHit),
    .dramRasN (dramRasN),
    .dramCasN (dramCasN),
    .dramWeN  (dramWeN),
    .dramAddr (dramAddr)
  );

endmodule

// File: tb/tb_dram_page_seq.sv
module tb_dram_page_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W    = 22;
  localparam int MA_W      = 11;
  localparam int MIN_SHIFT = 8;

  logic              clk = 1'b0;
  logic              rstPowerN = 1'b0, rstSoftN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [7:0]        cfgWdata = '0;
  logic [7:0]        cfgRdata;
  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady, accDone, refReq = 1'b0, refAck;
  logic              dramRasN, dramCasN, dramWeN;
  logic [MA_W-1:0]   dramAddr;

  always #4 clk = ~clk;   // 125 MHz

  dram_page_seq #(.ADDR_W(ADDR_W), .MA_W(MA_W), .MIN_SHIFT(MIN_SHIFT)) dut (
    .clk(clk), .rstPowerN(rstPowerN), .rstSoftN(rstSoftN),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqReady(reqReady), .accDone(accDone), .refReq(refReq), .refAck(refAck),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN), .dramAddr(dramAddr)
  );

  int checks = 0, failures = 0;
  int rasHighCnt = 0, casHighCnt = 0;

  always @(negedge clk) begin
    if (dramRasN === 1'b1) rasHighCnt++;
    if (dramCasN === 1'b1) casHighCnt++;
  end

  typedef struct packed {
    logic [1:0]  mux;
    logic [10:0] row;
    logic [10:0] col;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 11'h155, 11'h0A5},
    '{2'd1, 11'h2AA, 11'h1F0},
    '{2'd2, 11'h7FF, 11'h3FF},
    '{2'd3, 11'h001, 11'h7FE},
    '{2'd0, 11'h7FF, 11'h000},
    '{2'd3, 11'h400, 11'h001}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic setCfg(input logic [7:0] v);
    cfgWe = 1'b1;
    cfgWdata = v;
    step();
    cfgWe = 1'b0;
  endtask

  // Returns one cycle after acceptance, with reqValid dropped
  task automatic startReq(input logic w, input logic [ADDR_W-1:0] a);
    reqValid = 1'b1;
    reqWrite = w;
    reqAddr  = a;
    #1;
    for (int k = 0; k < 40 && !reqReady; k++) step();
    chk("R4 request accepted", int'(reqReady), 1);
    step();
    reqValid = 1'b0;
  endtask

  task automatic gapRun(input logic [ADDR_W-1:0] a, output int gap);
    int phase;
    phase = 0;
    gap = 0;
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqAddr  = a;
    for (int k = 0; k < 30 && phase < 3; k++) begin
      step();
      if (phase == 0) begin
        if (!dramRasN) phase = 1;
      end else if (phase == 1) begin
        if (dramRasN) begin
          phase = 2;
          gap = 1;
        end
      end else begin
        if (dramRasN) gap++;
        else phase = 3;
      end
    end
    reqValid = 1'b0;
    repeat (6) step();
  endtask

  task automatic doRefresh(input bit fromOpen, input int expWait,
                           input logic [ADDR_W-1:0] a, input int expRow);
    int n;
    refReq   = 1'b1;
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqAddr  = a;
    #1;
    chk("R11 no acceptance while refresh pending", int'(reqReady), 0);
    if (fromOpen) begin
      step();
      chk("R11 RAS raised before refresh", int'(dramRasN), 1);
      chk("R11 CAS high during precharge", int'(dramCasN), 1);
      chk("R11 ready low in precharge", int'(reqReady), 0);
    end
    step();
    chk("R10 CAS low first", int'(dramCasN), 0);
    chk("R10 RAS high while CAS falls", int'(dramRasN), 1);
    chk("R11 ready low in refresh", int'(reqReady), 0);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      if (dramRasN) break;
      n++;
      chk("R10 CAS low with RAS", int'(dramCasN), 0);
      chk("R10 WE high in refresh", int'(dramWeN), 1);
      chk("R11 ready low in refresh", int'(reqReady), 0);
      if (refAck) begin
        refReq = 1'b0;
        break;
      end
    end
    chk("R10 RAS-low refresh length", n, expWait + 1);
    step();
    chk("R10 RAS high after refresh", int'(dramRasN), 1);
    chk("R10 CAS high after refresh", int'(dramCasN), 1);
    chk("R11 pending request served after refresh", int'(reqReady), 1);
    step();
    reqValid = 1'b0;
    chk("R11 row strobe after refresh", int'(dramRasN), 0);
    chk("R11 row address after refresh", int'(dramAddr), expRow);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a, b, c;
    int g, rh, ch;

    // Reset state
    repeat (3) step();
    chk("R1 power reset clears config", int'(cfgRdata), 0);
    chk("R2 RAS idle in reset", int'(dramRasN), 1);
    chk("R2 CAS idle in reset", int'(dramCasN), 1);
    chk("R2 WE idle in reset", int'(dramWeN), 1);
    rstPowerN = 1'b1;
    rstSoftN  = 1'b1;
    step();
    chk("R2 ready low after reset", int'(reqReady), 0);
    chk("R2 RAS idle after reset", int'(dramRasN), 1);

    // R1 readback and soft reset retention
    setCfg(8'hA5);
    chk("R1 readback", int'(cfgRdata), 32'hA5);
    rstSoftN = 1'b0;
    step();
    step();
    rstSoftN = 1'b1;
    chk("R1 soft reset keeps config", int'(cfgRdata), 32'hA5);
    chk("R2 RAS idle after soft reset", int'(dramRasN), 1);
    chk("R2 CAS idle after soft reset", int'(dramCasN), 1);
    rstPowerN = 1'b0;
    step();
    rstPowerN = 1'b1;
    chk("R1 power reset clears again", int'(cfgRdata), 0);
    step();

    // Vector table: shift codes and full read timing
    foreach (VECS[i]) begin
      setCfg({4'b0000, VECS[i].mux, 2'b00});
      a = (ADDR_W'(VECS[i].row) << (MIN_SHIFT + int'(VECS[i].mux))) | ADDR_W'(VECS[i].col);
      startReq(1'b0, a);
      chk("R4 RAS low in row cycle", int'(dramRasN), 0);
      chk("R4 CAS high in row cycle", int'(dramCasN), 1);
      chk("R9 row address", int'(dramAddr), int'(VECS[i].row));
      step();
      chk("R4 CAS low in column cycle", int'(dramCasN), 0);
      chk("R9 column address", int'(dramAddr), int'(VECS[i].col));
      chk("R4 accDone in column cycle", int'(accDone), 1);
      chk("R4 WE high on read", int'(dramWeN), 1);
      step();
      chk("R4 RAS high after access", int'(dramRasN), 1);
      chk("R4 CAS high after access", int'(dramCasN), 1);
      step();
    end

    // R4 write access
    setCfg(8'h00);
    a = (ADDR_W'(11'h012) << 8) | ADDR_W'(11'h034);
    startReq(1'b1, a);
    chk("R4 WE high in row cycle", int'(dramWeN), 1);
    step();
    chk("R4 WE low in write column", int'(dramWeN), 0);
    chk("R4 accDone on write", int'(accDone), 1);
    step();
    chk("R4 WE high after write", int'(dramWeN), 1);
    chk("R4 accDone clear after column", int'(accDone), 0);
    step();

    // R3 precharge length
    gapRun(a, g);
    chk("R3 one precharge cycle", g, 1);
    setCfg(8'h80);
    gapRun(a, g);
    chk("R3 two precharge cycles", g, 2);

    // R5 / R7 burst with row released
    setCfg(8'h40);
    a = (ADDR_W'(11'h0AB) << 8) | ADDR_W'(11'h010);
    b = (ADDR_W'(11'h0AB) << 8) | ADDR_W'(11'h020);
    startReq(1'b0, a);
    step();
    rh = rasHighCnt;
    ch = casHighCnt;
    startReq(1'b0, b);
    chk("R5 RAS held through page access", rasHighCnt - rh, 0);
    chk("R5 one CAS-high cycle between columns", casHighCnt - ch, 1);
    chk("R5 CAS low on page access", int'(dramCasN), 0);
    chk("R5 new column on page access", int'(dramAddr), 32'h20);
    step();
    chk("R7 RAS still low in open cycle", int'(dramRasN), 0);
    chk("R7 CAS high in open cycle", int'(dramCasN), 1);
    step();
    chk("R7 RAS released without request", int'(dramRasN), 1);
    repeat (3) step();

    // R6 / R8 / R11 with row hold
    setCfg(8'h60);
    a = (ADDR_W'(11'h0CD) << 8) | ADDR_W'(11'h005);
    b = (ADDR_W'(11'h0CD) << 8) | ADDR_W'(11'h009);
    c = (ADDR_W'(11'h0CE) << 8) | ADDR_W'(11'h001);
    startReq(1'b0, a);
    step();
    step();
    rh = rasHighCnt;
    repeat (10) step();
    chk("R6 RAS held low while idle", int'(dramRasN), 0);
    chk("R6 no RAS-high cycle while idle", rasHighCnt - rh, 0);
    startReq(1'b0, b);
    chk("R6 held row serves page hit", int'(dramAddr), 32'h9);
    chk("R6 RAS never rose", rasHighCnt - rh, 0);
    step();
    rh = rasHighCnt;
    startReq(1'b0, c);
    chk("R8 new row address", int'(dramAddr), 32'h0CE);
    chk("R8 RAS low on new row", int'(dramRasN), 0);
    chk("R8 one precharge before new row", rasHighCnt - rh, 1);
    step();
    step();
    doRefresh(1'b1, 0, c, 32'h0CE);
    step();
    step();

    // R10 / R11 refresh from idle with three wait states
    setCfg(8'h03);
    repeat (4) step();
    a = (ADDR_W'(11'h033) << 8) | ADDR_W'(11'h044);
    doRefresh(1'b0, 3, a, 32'h033);
    repeat (4) step();

    // R6 row hold ignored without bursting
    setCfg(8'h20);
    startReq(1'b0, a);
    step();
    step();
    chk("R6 hold without burst releases RAS", int'(dramRasN), 1);
    repeat (3) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule